// File: doc/BRIEF.md
# Jack Detect Interrupt Register

This block is one 16-bit control and status register that watches two jack-detect pins. Each pin runs through a synchronizer and a debounce filter. The accepted level of each pin is shown in read-only bits. When an accepted level changes, a sticky per-input flag is set, so software sees the event even after the pin settles.

A per-input mode bit chooses how software learns of an event. In polled mode, software reads the flag. In interrupt mode, the flag also drives the shared interrupt output. Software can also raise a flag itself by writing 1 to it.

Two enable bits let either detected level force an equalizer-bypass output. The upper control field, the two downmix bits and the spread bit are only stored for other logic to use. The register is accessed through a synchronous bus with a write strobe, write data and combinational read data.

Top module: `jack_detect_reg`

## Requirements
- R1: After reset, with both pins low, `rd_data` reads 0x0000 and `irq_o` and `eq_bypass_o` are 0.
- R2: Bits 15:8 (15 spread for input 1, 14 downmix for input 1, 13 downmix for input 0, 12:10 mute field, 9 bypass enable for input 1, 8 bypass enable for input 0) read back exactly as last written. Bits 5:4 (5 mode for input 1, 4 mode for input 0) also read back exactly as last written. Bits 7:6 always read 0.
- R3: Bits 3 (input 1) and 2 (input 0) show the accepted level of each pin, and bus writes to them have no effect.
- R4: A pin level is accepted exactly SYNC_STAGES + STABLE_CYC clock edges after the pin changes, if it holds that long. A pulse shorter than STABLE_CYC cycles changes neither the level bit nor the flag.
- R5: An accepted level change in either direction sets that input's flag (bit 1 for input 1, bit 0 for input 0). The flag stays set until software clears it.
- R6: A bus write loads each flag from its write-data bit: 0 clears the flag and 1 sets it (a software interrupt).
- R7: If a flag's hardware set and a software clear land on the same edge, the flag ends up set.
- R8: `irq_o` is 1 exactly when some input has both its flag and its mode bit set. A flag on an input with mode 0 does not raise `irq_o`.
- R9: `eq_bypass_o` is 1 exactly when some input has both its bypass enable and its accepted level at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| det_i | input | 2 | Raw jack-detect pins, bit 0 is input 0 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| irq_o | output | 1 | Combined interrupt |
| eq_bypass_o | output | 1 | Equalizer bypass request |

## Verification
The bench samples the level bit one edge before and exactly at the expected acceptance edge. A filter that is too short or too long fails one of those two samples. A pulse one cycle shorter than the stable window is applied, and a filter without a counter would let it through as a level change and a flag. A clear written on the very edge where a pin change is accepted must leave the flag set; a design that gives the write priority would lose that event. Random register writes, with bits 3:2 and 7:6 toggled, expose write leakage into the read-only or unused bits, and polled-mode flags expose an interrupt that ignores the mode bit.

// File: rtl/jdr_pkg.sv
package jdr_pkg;
   localparam int REG_W    = 16;
   localparam int NUM_IN   = 2;
   localparam int FLAG_LSB = 0;
   localparam int LVL_LSB  = 2;
   localparam int MODE_LSB = 4;
   localparam int PAD_LSB  = 6;
   localparam int BYP_LSB  = 8;
   localparam int CTRL_LSB = 10;
   localparam int CTRL_W   = REG_W - CTRL_LSB;
endpackage

// File: rtl/jdr_sync_filter.sv
module jdr_sync_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic change_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   level_q;
   logic                   change_w;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (STABLE_CYC == 1) begin : g_direct
         assign change_w = (synced != level_q);
      end else begin : g_count
         localparam int CW = $clog2(STABLE_CYC);
         logic [CW-1:0] cnt_q;
         logic          done;
         assign done     = (cnt_q == CW'(STABLE_CYC - 1));
         assign change_w = (synced != level_q) && done;
         always_ff @(posedge clk) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (synced == level_q) cnt_q <= '0;
            else if (done)              cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        level_q <= 1'b0;
      else if (change_w) level_q <= synced;
   end

   assign level_o  = level_q;
   assign change_o = change_w;
endmodule

// File: rtl/jdr_flag_cell.sv
module jdr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set_i,
   input  logic wr_en_i,
   input  logic wr_bit_i,
   output logic flag_o
);
   logic flag_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hw_set_i) flag_q <= 1'b1;
      else if (wr_en_i)  flag_q <= wr_bit_i;
   end
   assign flag_o = flag_q;
endmodule

// File: rtl/jack_detect_reg.sv
module jack_detect_reg #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  det_i,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   output logic        irq_o,
   output logic        eq_bypass_o
);
   import jdr_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STABLE_CYC < 1) begin : g_bad_stable
         $error("STABLE_CYC must be at least 1");
      end
   endgenerate

   logic [NUM_IN-1:0] level_w;
   logic [NUM_IN-1:0] change_w;
   logic [NUM_IN-1:0] flag_w;
   logic [NUM_IN-1:0] mode_q;
   logic [NUM_IN-1:0] byp_q;
   logic [CTRL_W-1:0] ctrl_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IN; gi++) begin : g_in
         jdr_sync_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .STABLE_CYC (STABLE_CYC)
         ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (det_i[gi]),
            .level_o (level_w[gi]),
            .change_o(change_w[gi])
         );
         jdr_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set_i(change_w[gi]),
            .wr_en_i (wr_en),
            .wr_bit_i(wr_data[FLAG_LSB + gi]),
            .flag_o  (flag_w[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         byp_q  <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         mode_q <= wr_data[MODE_LSB +: NUM_IN];
         byp_q  <= wr_data[BYP_LSB  +: NUM_IN];
         ctrl_q <= wr_data[CTRL_LSB +: CTRL_W];
      end
   end

   always_comb begin
      rd_data = '0;
      rd_data[FLAG_LSB +: NUM_IN] = flag_w;
      rd_data[LVL_LSB  +: NUM_IN] = level_w;
      rd_data[MODE_LSB +: NUM_IN] = mode_q;
      rd_data[BYP_LSB  +: NUM_IN] = byp_q;
      rd_data[CTRL_LSB +: CTRL_W] = ctrl_q;
   end

   assign irq_o       = |(flag_w & mode_q);
   assign eq_bypass_o = |(byp_q & level_w);
endmodule

// File: rtl/jdr_chk.sv
module jdr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic [15:0] rd_data,
   input logic        irq_o,
   input logic        eq_bypass_o
);
   // R2
   stored_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (rd_data[15:8] == $past(wr_data[15:8])) &&
                       (rd_data[5:4]  == $past(wr_data[5:4])));
   // R2
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00);
   // R5
   lvl0_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[2]) |-> rd_data[0]);
   // R5
   lvl1_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[3]) |-> rd_data[1]);
   // R6
   flag0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[0]) |-> $past(wr_en) && !$past(wr_data[0]));
   // R6
   flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[1]) |-> $past(wr_en) && !$past(wr_data[1]));
   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $stable(rd_data[3:2])) |-> $stable(rd_data[1:0]));
   // R8
   irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(rd_data[1:0] & rd_data[5:4]));
   // R9
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eq_bypass_o == |(rd_data[9:8] & rd_data[3:2]));
endmodule

bind jack_detect_reg jdr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .irq_o      (irq_o),
   .eq_bypass_o(eq_bypass_o)
);

// File: tb/jack_detect_reg_tb.sv
module jack_detect_reg_tb;
   localparam int SYNC = 2;
   localparam int STAB = 4;
   localparam int LAT  = SYNC + STAB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  det_i = 2'b00;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = 16'h0000;
   logic [15:0] rd_data;
   logic        irq_o;
   logic        eq_bypass_o;

   int total = 0;
   int bad = 0;

   logic [1:0] m_flag = 0, m_lvl = 0, m_mode = 0, m_byp = 0;
   logic [5:0] m_ctrl = 0;

   always #5 clk = ~clk;

   jack_detect_reg #(.SYNC_STAGES(SYNC), .STABLE_CYC(STAB)) u_dut (
      .clk(clk), .rst_n(rst_n), .det_i(det_i), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o),
      .eq_bypass_o(eq_bypass_o));

   function automatic logic [15:0] exp_rd();
      return {m_ctrl, m_byp, 2'b00, m_mode, m_lvl, m_flag};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk({req, " rd_data"}, rd_data, exp_rd());
      chk("R8 irq", {15'd0, irq_o}, {15'd0, |(m_flag & m_mode)});
      chk("R9 bypass", {15'd0, eq_bypass_o}, {15'd0, |(m_byp & m_lvl)});
   endtask

   task automatic do_write(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      m_flag = d[1:0]; m_mode = d[5:4]; m_byp = d[9:8]; m_ctrl = d[15:10];
   endtask

   task automatic set_pin(input int idx, input logic v);
      @(negedge clk);
      det_i[idx] = v;
      repeat (LAT + 1) @(negedge clk);
      if (m_lvl[idx] != v) begin m_lvl[idx] = v; m_flag[idx] = 1'b1; end
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset", rd_data, 16'h0000);
      chk("R1 irq", {15'd0, irq_o}, 16'd0);

      // R2 R3 R6: all ones written, bits 7:6 and 3:2 must not take them
      do_write(16'hFFFF);
      chk_all("R2 R3 R6 write ones");
      do_write(16'h0000);
      chk_all("R6 clear");

      // R4 latency and R5 set, polled mode (R8)
      @(negedge clk);
      det_i[0] = 1'b1;
      repeat (LAT - 1) @(negedge clk);
      chk("R4 before accept", rd_data, 16'h0000);
      @(negedge clk);
      m_lvl[0] = 1'b1; m_flag[0] = 1'b1;
      chk_all("R4 R5 accept edge");
      repeat (10) @(negedge clk);
      chk_all("R5 sticky");

      // R4 short pulse ignored
      @(negedge clk);
      det_i[1] = 1'b1;
      repeat (STAB - 1) @(negedge clk);
      det_i[1] = 1'b0;
      repeat (LAT + 4) @(negedge clk);
      chk_all("R4 glitch ignored");

      // R8 interrupt mode on input 1
      do_write(16'h0020);
      chk_all("R8 no flag");
      set_pin(1, 1'b1);
      chk_all("R8 irq mode");
      do_write(16'h0010);
      chk_all("R6 R8 cleared");

      // R7 hardware set beats same-edge clear
      @(negedge clk);
      det_i[0] = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h0010;
      @(negedge clk);
      wr_en = 1'b0;
      m_lvl[0] = 1'b0; m_flag = 2'b01; m_mode = 2'b01;
      chk_all("R7 set wins");

      // R9 bypass per input (level0=0, level1=1)
      do_write(16'h0100);
      chk_all("R9 enable0 level low");
      do_write(16'h0200);
      chk_all("R9 enable1 level high");

      // R3 writes to level bits ignored
      do_write(16'h000C ^ {14'd0, 2'b00});
      chk_all("R3 level bits write");

      // random phase
      for (int i = 0; i < 300; i++) begin
         int sel = $urandom_range(0, 3);
         if (sel < 2) do_write(16'($urandom));
         else if (sel == 2) set_pin($urandom_range(0, 1), 1'($urandom));
         else repeat (3) @(negedge clk);
         chk_all("R2 R5 R6 R8 R9 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule